// File: doc/BRIEF.md
# Line-Aware Display Address Counter

This block holds the 7-bit RAM address used by a character display controller for host reads and writes. A set-address command loads it. After each RAM access it moves one location up or down. While it points into display RAM it does not roll over at a power of two. It follows the line layout of the selected display arrangement instead, so a host can stream characters and land on the start of the next line without reloading the address.

While it points into character-pattern RAM, the counter is a plain 6-bit up/down counter and ignores the display arrangement. RAM storage and display shifting are handled elsewhere. This block only produces the address.

Top module: `ddram_addr_ctr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr` becomes 00h.
- R2: `load_en` high loads the counter at the next edge and takes priority over `step_en` in the same cycle. With `ram_sel`=0 (display RAM) all 7 bits of `load_val` are taken as they are, even outside the valid range. With `ram_sel`=1 (character RAM) only `load_val[5:0]` is kept and bit 6 is cleared.
- R3: With `load_en` and `step_en` both low, `addr` holds its value.
- R4: `disp_mode`=0 (one line of 80 cells) uses the range 00h–4Fh. Stepping up from 4Fh gives 00h, and stepping down from 00h gives 4Fh.
- R5: `disp_mode`=1 (two lines) uses the ranges 00h–27h and 40h–67h. Stepping up goes from 27h to 40h and from 67h to 00h. Stepping down goes from 40h to 27h and from 00h to 67h.
- R6: `disp_mode`=2 (one line of 40 cells) uses the range 00h–27h. Stepping up from 27h gives 00h, and stepping down from 00h gives 27h.
- R7: `disp_mode`=3 behaves exactly as `disp_mode`=0.
- R8: In display RAM, a step from an address outside the valid ranges goes to the nearest valid address in the step direction. If there is none, it wraps to the first valid address when stepping up, or to the last valid address when stepping down. Examples in two-line mode: 30h goes to 40h up and 27h down, and 70h goes to 00h up and 67h down.
- R9: With `ram_sel`=1, a step moves `addr` by one modulo 64 whatever `disp_mode` is. The result always has bit 6 clear.
- R10: `step_en` high with `load_en` low moves the address at the next edge. `step_up`=1 steps up and `step_up`=0 steps down. Inside a range, a step changes the address by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the counter from `load_val` |
| load_val | input | 7 | Address to load |
| ram_sel | input | 1 | 0 selects display RAM, 1 selects character RAM |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| step_en | input | 1 | Step strobe, one per RAM access |
| disp_mode | input | 2 | Display arrangement code (0, 1, 2, 3) |
| addr | output | 7 | Current address |

## Verification
The hardest cases to reach are steps that start from an address outside every valid range, such as the gap between the two lines or the space above the last line. In normal stepping the counter never enters these regions. The stimulus reaches them by loading such addresses directly in display RAM and then stepping both ways under each arrangement. A random phase then mixes loads, steps, arrangement changes and RAM switches, so that addresses with bit 6 set reach the character-RAM stepper and out-of-range values reach the display stepper. Every cycle is compared against a model that walks an ordered list of valid addresses.

// File: rtl/ddram_ac_pkg.sv
package ddram_ac_pkg;

    localparam int unsigned ADDR_W = 7;
    localparam int unsigned CHAR_W = 6;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        DM_WIDE   = 2'd0,
        DM_TWO    = 2'd1,
        DM_NARROW = 2'd2,
        DM_RSVD   = 2'd3
    } disp_mode_e;

    typedef enum logic {
        RAM_DISP = 1'b0,
        RAM_CHAR = 1'b1
    } ram_sel_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    // Line layout: first range lo0..hi0, optional second range lo1..hi1
    typedef struct packed {
        addr_t lo0;
        addr_t hi0;
        addr_t lo1;
        addr_t hi1;
        logic  two;
    } line_map_t;

    typedef struct packed {
        logic       load;
        addr_t      val;
        logic       step;
        ram_sel_e   sel;
        step_dir_e  dir;
        disp_mode_e mode;
    } ctl_t;

    function automatic line_map_t map_for(disp_mode_e m);
        line_map_t r;
        r.lo0 = addr_t'(8'h00);
        r.lo1 = addr_t'(8'h00);
        r.hi1 = addr_t'(8'h00);
        r.two = 1'b0;
        case (m)
            DM_TWO: begin
                r.hi0 = addr_t'(8'h27);
                r.lo1 = addr_t'(8'h40);
                r.hi1 = addr_t'(8'h67);
                r.two = 1'b1;
            end
            DM_NARROW: r.hi0 = addr_t'(8'h27);
            default:   r.hi0 = addr_t'(8'h4F);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ac_disp_next.sv
module ac_disp_next
    import ddram_ac_pkg::*;
(
    input  addr_t      cur,
    input  disp_mode_e mode,
    input  step_dir_e  dir,
    output addr_t      nxt
);
    line_map_t lm;
    addr_t     up_v;
    addr_t     dn_v;

    assign lm = map_for(mode);

    always_comb begin
        if (lm.two) begin
            if (cur < lm.hi0)       up_v = cur + addr_t'(1);
            else if (cur < lm.lo1)  up_v = lm.lo1;
            else if (cur < lm.hi1)  up_v = cur + addr_t'(1);
            else                    up_v = lm.lo0;
        end else begin
            if (cur < lm.hi0)       up_v = cur + addr_t'(1);
            else                    up_v = lm.lo0;
        end
    end

    always_comb begin
        if (lm.two) begin
            if (cur == lm.lo0)       dn_v = lm.hi1;
            else if (cur <= lm.hi0)  dn_v = cur - addr_t'(1);
            else if (cur <= lm.lo1)  dn_v = lm.hi0;
            else if (cur <= lm.hi1)  dn_v = cur - addr_t'(1);
            else                     dn_v = lm.hi1;
        end else begin
            if (cur == lm.lo0)       dn_v = lm.hi0;
            else if (cur <= lm.hi0)  dn_v = cur - addr_t'(1);
            else                     dn_v = lm.hi0;
        end
    end

    assign nxt = (dir == DIR_UP) ? up_v : dn_v;
endmodule

// File: rtl/ac_char_next.sv
module ac_char_next
    import ddram_ac_pkg::*;
#(
    parameter int unsigned CW = CHAR_W
)(
    input  addr_t     cur,
    input  step_dir_e dir,
    output addr_t     nxt
);
    logic [CW-1:0] low;

    assign low = (dir == DIR_UP) ? (cur[CW-1:0] + 1'b1) : (cur[CW-1:0] - 1'b1);

    generate
        if (CW < ADDR_W) begin : g_pad
            assign nxt = {{(ADDR_W-CW){1'b0}}, low};
        end else begin : g_full
            assign nxt = addr_t'(low);
        end
    endgenerate
endmodule

// File: rtl/ddram_addr_ctr.sv
module ddram_addr_ctr
    import ddram_ac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic [6:0] load_val,
    input  logic       ram_sel,
    input  logic       step_up,
    input  logic       step_en,
    input  logic [1:0] disp_mode,
    output logic [6:0] addr
);
    ctl_t  ctl;
    addr_t addr_q;
    addr_t disp_nxt;
    addr_t char_nxt;
    addr_t load_fmt;

    assign ctl.load = load_en;
    assign ctl.val  = load_val;
    assign ctl.step = step_en;
    assign ctl.sel  = ram_sel_e'(ram_sel);
    assign ctl.dir  = step_dir_e'(step_up);
    assign ctl.mode = disp_mode_e'(disp_mode);

    ac_disp_next u_disp (
        .cur  (addr_q),
        .mode (ctl.mode),
        .dir  (ctl.dir),
        .nxt  (disp_nxt)
    );

    ac_char_next #(.CW(CHAR_W)) u_char (
        .cur (addr_q),
        .dir (ctl.dir),
        .nxt (char_nxt)
    );

    assign load_fmt = (ctl.sel == RAM_CHAR)
                    ? {{(ADDR_W-CHAR_W){1'b0}}, ctl.val[CHAR_W-1:0]}
                    : ctl.val;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (ctl.load)
            addr_q <= load_fmt;
        else if (ctl.step)
            addr_q <= (ctl.sel == RAM_CHAR) ? char_nxt : disp_nxt;
    end

    assign addr = addr_q;
endmodule

// File: rtl/ddram_addr_ctr_chk.sv
module ddram_addr_ctr_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic [6:0] load_val,
    input logic       ram_sel,
    input logic       step_up,
    input logic       step_en,
    input logic [1:0] disp_mode,
    input logic [6:0] addr
);
    a_r2_load_disp: assert property (@(posedge clk) disable iff (rst)
        load_en && !ram_sel |=> addr == $past(load_val));

    a_r2_load_char: assert property (@(posedge clk) disable iff (rst)
        load_en && ram_sel |=> addr == {1'b0, $past(load_val[5:0])});

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !load_en && !step_en |=> $stable(addr));

    a_r4_wide_wrap: assert property (@(posedge clk) disable iff (rst)
        !load_en && step_en && !ram_sel && step_up && disp_mode == 2'd0
        && addr == 7'h4F |=> addr == 7'h00);

    a_r5_gap_jump: assert property (@(posedge clk) disable iff (rst)
        !load_en && step_en && !ram_sel && step_up && disp_mode == 2'd1
        && addr == 7'h27 |=> addr == 7'h40);

    a_r9_char_range: assert property (@(posedge clk) disable iff (rst)
        !load_en && step_en && ram_sel |=> addr[6] == 1'b0);

    a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
        !load_en && step_en && !ram_sel && step_up && addr < 7'h26
        |=> addr == $past(addr) + 7'd1);
endmodule

bind ddram_addr_ctr ddram_addr_ctr_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_val  (load_val),
    .ram_sel   (ram_sel),
    .step_up   (step_up),
    .step_en   (step_en),
    .disp_mode (disp_mode),
    .addr      (addr)
);

// File: tb/test_ddram_addr_ctr.sv
`timescale 1ns/1ps
module test_ddram_addr_ctr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [6:0] load_val = '0;
    logic       ram_sel = 1'b0;
    logic       step_up = 1'b1;
    logic       step_en = 1'b0;
    logic [1:0] disp_mode = 2'd0;
    logic [6:0] addr;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    exp_a = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ddram_addr_ctr i_ddram_addr_ctr (
        .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
        .ram_sel(ram_sel), .step_up(step_up), .step_en(step_en),
        .disp_mode(disp_mode), .addr(addr)
    );

    // Ordered list of valid display addresses, searched for the next one
    function automatic int ref_next(int a, int md, bit sel, bit up);
        int q[$];
        int m = (md == 3) ? 0 : md;
        if (sel) return up ? ((a + 1) & 63) : ((a + 63) & 63);
        if (m == 0) for (int i = 0; i < 80; i++) q.push_back(i);
        else if (m == 1) begin
            for (int i = 0; i < 40; i++) q.push_back(i);
            for (int i = 64; i < 104; i++) q.push_back(i);
        end else for (int i = 0; i < 40; i++) q.push_back(i);
        if (up) begin
            foreach (q[k]) if (q[k] > a) return q[k];
            return q[0];
        end else begin
            for (int k = q.size() - 1; k >= 0; k--) if (q[k] < a) return q[k];
            return q[q.size() - 1];
        end
    endfunction

    always @(posedge clk) begin
        if (rst) exp_a <= 0;
        else if (load_en) exp_a <= ram_sel ? (int'(load_val) & 63) : int'(load_val);
        else if (step_en) exp_a <= ref_next(exp_a, int'(disp_mode), ram_sel, step_up);
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            total++;
            if (int'(addr) !== exp_a) begin
                bad++;
                $display("FAIL %s: addr=%02h expected=%02h", cur_req, addr, exp_a[6:0]);
            end
        end
    end

    task automatic drive(input bit ld, input logic [6:0] v, input bit sel,
                         input bit up, input bit st, input logic [1:0] md, input string rq);
        @(negedge clk);
        load_en = ld; load_val = v; ram_sel = sel; step_up = up;
        step_en = st; disp_mode = md; cur_req = rq;
    endtask

    task automatic steps(input int n, input bit sel, input bit up,
                         input logic [1:0] md, input string rq);
        for (int i = 0; i < n; i++) drive(1'b0, 7'h00, sel, up, 1'b1, md, rq);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: addr=%02h expected=finish", addr);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        drive(1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 2'd0, "R1");
        rst = 1'b0;
        // R1: reset mid-run
        drive(1'b1, 7'h33, 1'b0, 1'b1, 1'b0, 2'd0, "R2");
        @(negedge clk); rst = 1'b1; cur_req = "R1";
        @(negedge clk); rst = 1'b0;
        // R4
        drive(1'b1, 7'h4D, 1'b0, 1'b1, 1'b0, 2'd0, "R2");
        steps(4, 1'b0, 1'b1, 2'd0, "R4");
        steps(3, 1'b0, 1'b0, 2'd0, "R4");
        // R5
        drive(1'b1, 7'h26, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(3, 1'b0, 1'b1, 2'd1, "R5");
        steps(3, 1'b0, 1'b0, 2'd1, "R5");
        drive(1'b1, 7'h66, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(3, 1'b0, 1'b1, 2'd1, "R5");
        steps(3, 1'b0, 1'b0, 2'd1, "R5");
        // R6
        drive(1'b1, 7'h26, 1'b0, 1'b1, 1'b0, 2'd2, "R2");
        steps(3, 1'b0, 1'b1, 2'd2, "R6");
        steps(3, 1'b0, 1'b0, 2'd2, "R6");
        // R7
        drive(1'b1, 7'h4E, 1'b0, 1'b1, 1'b0, 2'd3, "R2");
        steps(3, 1'b0, 1'b1, 2'd3, "R7");
        steps(2, 1'b0, 1'b0, 2'd3, "R7");
        // R8: out-of-range starts
        drive(1'b1, 7'h30, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(1, 1'b0, 1'b1, 2'd1, "R8");
        drive(1'b1, 7'h30, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(1, 1'b0, 1'b0, 2'd1, "R8");
        drive(1'b1, 7'h70, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(1, 1'b0, 1'b1, 2'd1, "R8");
        drive(1'b1, 7'h70, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(1, 1'b0, 1'b0, 2'd1, "R8");
        drive(1'b1, 7'h7F, 1'b0, 1'b1, 1'b0, 2'd0, "R2");
        steps(1, 1'b0, 1'b0, 2'd0, "R8");
        drive(1'b1, 7'h50, 1'b0, 1'b1, 1'b0, 2'd2, "R2");
        steps(1, 1'b0, 1'b1, 2'd2, "R8");
        drive(1'b1, 7'h50, 1'b0, 1'b1, 1'b0, 2'd2, "R2");
        steps(1, 1'b0, 1'b0, 2'd2, "R8");
        // R9: character RAM, bit 6 dropped on load
        drive(1'b1, 7'h7E, 1'b1, 1'b1, 1'b0, 2'd1, "R2");
        steps(3, 1'b1, 1'b1, 2'd1, "R9");
        steps(3, 1'b1, 1'b0, 2'd2, "R9");
        drive(1'b1, 7'h45, 1'b0, 1'b1, 1'b0, 2'd1, "R2");
        steps(2, 1'b1, 1'b1, 2'd0, "R9");
        // R2: load beats step
        drive(1'b1, 7'h12, 1'b0, 1'b1, 1'b1, 2'd0, "R2");
        drive(1'b1, 7'h27, 1'b0, 1'b0, 1'b1, 2'd1, "R2");
        // R3: idle with mode and direction toggling
        drive(1'b0, 7'h55, 1'b0, 1'b0, 1'b0, 2'd2, "R3");
        drive(1'b0, 7'h66, 1'b1, 1'b1, 1'b0, 2'd3, "R3");
        drive(1'b0, 7'h11, 1'b0, 1'b1, 1'b0, 2'd1, "R3");
        // R10: interior stepping
        drive(1'b1, 7'h10, 1'b0, 1'b1, 1'b0, 2'd0, "R2");
        steps(5, 1'b0, 1'b1, 2'd0, "R10");
        steps(5, 1'b0, 1'b0, 2'd2, "R10");
        // mixed random phase
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom_range(0, 99);
            drive(r < 12, 7'($urandom), 1'($urandom_range(0, 3) == 0),
                  1'($urandom), r < 85, 2'($urandom), "R10");
        end
        drive(1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 2'd0, "R3");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule